// File: doc/BRIEF.md
# Host-Core Interrupt Doorbell

This block carries interrupt requests both ways between an external host system and an embedded processor core. It holds two event flags. The doorbell flag is raised by the host and can only be cleared by the core. The uplink flag is raised by the core and can only be cleared by the host. The side that raises a flag never clears it. The side that receives a flag acknowledges it by writing 1 to it.

Each side has its own write port. A write presents a set of command bits for one cycle. The core also owns an enable mask that decides whether the doorbell flag reaches the core interrupt line. The host owns a hold bit that keeps the uplink flag off the host interrupt line while it is 1.

Each flag is a two-state machine with the states FLAG_IDLE and FLAG_PEND:
- The transition FLAG_IDLE to FLAG_PEND is named "raise" and fires on a set command.
- The transition FLAG_PEND to FLAG_IDLE is named "acknowledge" and fires on a clear command with no set command in the same cycle.

Each interrupt line is driven by a two-state machine with the states IRQ_QUIET and IRQ_ACTIVE:
- The transition IRQ_QUIET to IRQ_ACTIVE is named "assert" and fires when the flag is pending and its gate is open.
- The transition IRQ_ACTIVE to IRQ_QUIET is named "deassert" and fires when the flag is no longer pending or the gate is closed.

Both interrupt lines are registered and level-sensitive.

Top module: `hcdb_doorbell`

## Requirements
- R1: After reset, both flags, the enable mask and the hold bit are 0, and both interrupt outputs are 0.
- R2: A host write with `host_ring`=1 makes `core_db_o` read 1 from the next cycle onward.
- R3: A core write with `core_clr`=1 clears `core_db_o` in the next cycle. A core write with `core_clr`=0 leaves the doorbell flag unchanged.
- R4: A core write with `core_raise`=1 makes `host_db_o` read 1 in the next cycle. A core write with `core_raise`=0 leaves the uplink flag unchanged.
- R5: The uplink flag stays 1 until a host write with `host_ack`=1, which clears it in the next cycle. Core writes never clear it.
- R6: `irq_core_o` equals the doorbell flag ANDed with the enable mask, one cycle later.
- R7: `irq_host_o` equals the uplink flag ANDed with the inverse of the hold bit, one cycle later.
- R8: When a set and a clear reach the same flag in the same cycle, the flag ends at 1.
- R9: Every core write loads the enable mask from `core_mask`, and every host write loads the hold bit from `host_hold`. A write from the other side leaves these bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_ring | input | 1 | Host command: raise the doorbell flag |
| host_ack | input | 1 | Host command: clear the uplink flag |
| host_hold | input | 1 | Value loaded into the hold bit |
| core_we | input | 1 | Core write strobe |
| core_clr | input | 1 | Core command: clear the doorbell flag |
| core_raise | input | 1 | Core command: raise the uplink flag |
| core_mask | input | 1 | Value loaded into the enable mask |
| core_db_o | output | 1 | Doorbell flag readback |
| host_db_o | output | 1 | Uplink flag readback |
| irq_core_o | output | 1 | Interrupt line to the core |
| irq_host_o | output | 1 | Interrupt line to the host |

## Verification
Two functions can act in the same cycle: a raise from one side and an acknowledge from the other side, aimed at the same flag. The bench provokes this by driving the host write and the core write in a single cycle. It does this once with a ring and a doorbell clear, and once with an uplink raise and a host acknowledge. In both cases it judges the flag readback on the following cycle, which must be 1. It then clears the flag with a separate write, to show that the clear path still works after the collision.

// File: rtl/hcdb_pkg.sv
package hcdb_pkg;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/hcdb_flag.sv
module hcdb_flag
    import hcdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // raise / acknowledge; a set in the same cycle as a clear wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i)           state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:                        state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb pend_o = (state_q == FLAG_PEND);

endmodule

// File: rtl/hcdb_irq_gate.sv
module hcdb_irq_gate
    import hcdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic open_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       want;

    always_comb begin
        want    = pend_i && open_i;
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (want)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!want) state_d = IRQ_QUIET;
            default:               state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb irq_o = (state_q == IRQ_ACTIVE);

endmodule

// File: rtl/hcdb_ctl_bit.sv
module hcdb_ctl_bit #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic d_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= RESET_VAL;
        else if (we_i) q_o <= d_i;
    end

endmodule

// File: rtl/hcdb_doorbell.sv
module hcdb_doorbell (
    input  logic clk,
    input  logic rst_n,
    input  logic host_we,
    input  logic host_ring,
    input  logic host_ack,
    input  logic host_hold,
    input  logic core_we,
    input  logic core_clr,
    input  logic core_raise,
    input  logic core_mask,
    output logic core_db_o,
    output logic host_db_o,
    output logic irq_core_o,
    output logic irq_host_o
);

    logic mask_q;
    logic hold_q;
    logic db_set, db_clr, up_set, up_clr;

    always_comb begin
        db_set = host_we && host_ring;
        db_clr = core_we && core_clr;
        up_set = core_we && core_raise;
        up_clr = host_we && host_ack;
    end

    hcdb_ctl_bit #(.RESET_VAL(1'b0)) u_mask (
        .clk(clk), .rst_n(rst_n), .we_i(core_we), .d_i(core_mask), .q_o(mask_q)
    );

    hcdb_ctl_bit #(.RESET_VAL(1'b0)) u_hold (
        .clk(clk), .rst_n(rst_n), .we_i(host_we), .d_i(host_hold), .q_o(hold_q)
    );

    hcdb_flag u_db_flag (
        .clk(clk), .rst_n(rst_n), .set_i(db_set), .clr_i(db_clr), .pend_o(core_db_o)
    );

    hcdb_flag u_up_flag (
        .clk(clk), .rst_n(rst_n), .set_i(up_set), .clr_i(up_clr), .pend_o(host_db_o)
    );

    hcdb_irq_gate u_core_gate (
        .clk(clk), .rst_n(rst_n), .pend_i(core_db_o), .open_i(mask_q), .irq_o(irq_core_o)
    );

    hcdb_irq_gate u_host_gate (
        .clk(clk), .rst_n(rst_n), .pend_i(host_db_o), .open_i(!hold_q), .irq_o(irq_host_o)
    );

endmodule

// File: rtl/hcdb_checker.sv
module hcdb_checker (
    input logic clk,
    input logic rst_n,
    input logic host_we,
    input logic host_ring,
    input logic host_ack,
    input logic core_we,
    input logic core_clr,
    input logic core_raise,
    input logic core_db_o,
    input logic host_db_o,
    input logic irq_core_o,
    input logic irq_host_o,
    input logic mask_q,
    input logic hold_q
);

    assert_ring_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_ring) |=> core_db_o);

    assert_clr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && core_clr && !(host_we && host_ring)) |=> !core_db_o);

    assert_raise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && core_raise) |=> host_db_o);

    assert_uplink_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_db_o && !(host_we && host_ack)) |=> host_db_o);

    assert_core_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_core_o == $past(core_db_o && mask_q));

    assert_host_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_host_o == $past(host_db_o && !hold_q));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_ring && core_we && core_clr) |=> core_db_o);

    assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_we |=> $stable(mask_q));

endmodule

bind hcdb_doorbell hcdb_checker chk_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_ring(host_ring), .host_ack(host_ack),
    .core_we(core_we), .core_clr(core_clr), .core_raise(core_raise),
    .core_db_o(core_db_o), .host_db_o(host_db_o),
    .irq_core_o(irq_core_o), .irq_host_o(irq_host_o),
    .mask_q(mask_q), .hold_q(hold_q)
);

// File: tb/hcdb_doorbell_tb_top.sv
module hcdb_doorbell_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 0, host_ring = 0, host_ack = 0, host_hold = 0;
    logic core_we = 0, core_clr = 0, core_raise = 0, core_mask = 0;
    logic core_db_o, host_db_o, irq_core_o, irq_host_o;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    hcdb_doorbell dut_i (.*);

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // each write spans one rising edge; returns at the following falling edge
    task automatic host_write(input logic ring, input logic ack, input logic hold);
        host_we = 1; host_ring = ring; host_ack = ack; host_hold = hold;
        @(negedge clk);
        host_we = 0; host_ring = 0; host_ack = 0; host_hold = 0;
    endtask

    task automatic core_write(input logic clr, input logic raise, input logic mask);
        core_we = 1; core_clr = clr; core_raise = raise; core_mask = mask;
        @(negedge clk);
        core_we = 0; core_clr = 0; core_raise = 0; core_mask = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "core_db", core_db_o, 0);
        check("R1", "host_db", host_db_o, 0);
        check("R1", "irq_core", irq_core_o, 0);
        check("R1", "irq_host", irq_host_o, 0);
        rst_n = 1;
        idle();
        check("R1", "irq_core after release", irq_core_o, 0);
    endtask

    task automatic t_doorbell();
        host_write(1, 0, 0);
        check("R2", "core_db after ring", core_db_o, 1);
        idle();
        check("R6", "irq_core masked", irq_core_o, 0);
        core_write(0, 0, 1);
        check("R3", "core_db after clr=0", core_db_o, 1);
        idle();
        check("R6", "irq_core unmasked", irq_core_o, 1);
        host_write(0, 0, 0);
        idle();
        check("R9", "irq_core after host write", irq_core_o, 1);
        core_write(1, 0, 1);
        check("R3", "core_db after clr", core_db_o, 0);
        idle();
        check("R6", "irq_core after clear", irq_core_o, 0);
        core_write(0, 0, 0);
    endtask

    task automatic t_uplink();
        core_write(0, 0, 0);
        check("R4", "host_db after raise=0", host_db_o, 0);
        core_write(0, 1, 0);
        check("R4", "host_db after raise", host_db_o, 1);
        idle();
        check("R7", "irq_host open", irq_host_o, 1);
        host_write(0, 0, 1);
        check("R5", "host_db kept by host write without ack", host_db_o, 1);
        idle();
        check("R7", "irq_host held", irq_host_o, 0);
        core_write(1, 0, 0);
        check("R5", "host_db kept by core write", host_db_o, 1);
        core_write(0, 0, 0);
        idle();
        check("R9", "irq_host hold kept over core write", irq_host_o, 0);
        host_write(0, 0, 0);
        idle();
        check("R7", "irq_host after hold released", irq_host_o, 1);
        host_write(0, 1, 0);
        check("R5", "host_db after ack", host_db_o, 0);
        idle();
        check("R7", "irq_host after ack", irq_host_o, 0);
    endtask

    task automatic t_collide();
        host_we = 1; host_ring = 1;
        core_we = 1; core_clr = 1; core_mask = 1;
        @(negedge clk);
        host_we = 0; host_ring = 0; core_we = 0; core_clr = 0; core_mask = 0;
        check("R8", "core_db ring+clr", core_db_o, 1);
        core_write(1, 0, 0);
        check("R3", "core_db clear after collision", core_db_o, 0);
        host_we = 1; host_ack = 1;
        core_we = 1; core_raise = 1;
        @(negedge clk);
        host_we = 0; host_ack = 0; core_we = 0; core_raise = 0;
        check("R8", "host_db raise+ack", host_db_o, 1);
        host_write(0, 1, 0);
        check("R5", "host_db clear after collision", host_db_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_doorbell();
        t_uplink();
        t_collide();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule